// File: doc/BRIEF.md
# Machine and Supervisor Control Register Write-Mask Unit

This block holds the privileged control registers that a hart needs for traps and interrupts: the status word, the interrupt-enable and interrupt-pending words, interrupt delegation, the two trap-vector bases, the ISA descriptor and the two counter-enable masks. Every software write passes through a per-register legality mask, so the stored value is always a legal one no matter what is written. The supervisor status, supervisor interrupt-enable and supervisor interrupt-pending addresses have no storage of their own. Each one is a masked window onto the matching machine register.

The core presents one 12-bit register address. A write strobe with write data commits a write on the next rising clock edge. The read data and an illegal-access flag are produced combinationally from the same address and the current privilege level. This is a control port, not a data stream. A write is accepted in every cycle it is strobed, with no back-pressure, and the read result is valid in the same cycle the address is presented. Two hardware lines supply the machine software and machine timer pending bits. The block raises a one-cycle request to flush address translation when a status write changes a field that affects translation. Counter storage lives elsewhere. The block only decides whether a user-level counter read is permitted at the current privilege.

Top module: `csr_wmask_unit`

## Requirements
- R1: In the interrupt-pending word (address 0x344), software can change only bit 1 (supervisor software) and bit 5 (supervisor timer). Bit 3 reads the machine software input and bit 7 reads the machine timer input. All other bits read 0.
- R2: The interrupt-enable word (0x304) keeps bits 1, 3, 5, 7, 9 and 12 of a write. The delegation word (0x303) keeps only bits 1, 5, 9 and 12. Every other bit of both reads 0.
- R3: A write to the supervisor status alias (0x100) changes only these status fields: bit 1, bit 5, bit 8, bits 14:13 (FS), bits 16:15 (XS) and bit 18. Reading the alias returns the status word restricted to those fields, plus the summary bit.
- R4: The summary bit is the top bit (bit XLEN-1) of the status word (0x300) and of its supervisor alias. It reads 1 exactly when FS equals 3 or XS equals 3.
- R5: A write to the supervisor pending alias (0x144) changes pending bit 1, and only when delegation bit 1 is set. A write to the supervisor enable alias (0x104) changes the enable bits only at positions that are set in the delegation word. Reads of both aliases return the machine word ANDed with the delegation word.
- R6: The machine trap vector (0x305) and the supervisor trap vector (0x105) store write data with bits 1:0 forced to 0. The machine vector resets to 0x100.
- R7: The ISA word (0x301) resets to the maximum ISA value. Its MXL field and its I, S and U bits cannot be changed. Bits 0, 2, 3, 5 and 12 are writable where the maximum ISA has them. A write with bit 5 (F) clear also clears bit 3 (D).
- R8: A read of a user counter address 0xC00–0xC1F returns 0 when it is permitted, and is flagged illegal otherwise. Privilege is encoded as 0 for user, 1 for supervisor and 3 for machine. Machine mode is always permitted. Below machine mode, the bit indexed by address bits 4:0 must be set in the machine counter-enable word (0x306). In user mode, the same bit must also be set in the supervisor counter-enable word (0x106).
- R9: Performance counters 3–31 (0xB03–0xB1F) and their event selectors (0x323–0x33F) read 0 and are never flagged illegal.
- R10: A write to the status word (0x300) that changes MPP (bits 12:11), MPRV (bit 17), PUM (bit 18) or MXR (bit 19) raises the flush output for exactly the cycle after the write edge. A write through the supervisor alias, or a write that leaves those fields unchanged, does not raise it.
- R11: A read of an address that the block does not implement raises the illegal flag and returns 0. A write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| csr_addr_i | input | 12 | Register address for both read and write |
| csr_wr_i | input | 1 | Write strobe; the write commits at the next rising edge |
| csr_wdata_i | input | XLEN | Write data |
| hw_msip_i | input | 1 | Machine software interrupt pending, from hardware |
| hw_mtip_i | input | 1 | Machine timer interrupt pending, from hardware |
| csr_rdata_o | output | XLEN | Combinational read data |
| csr_illegal_o | output | 1 | Combinational illegal-access flag for the presented address |
| tlb_flush_o | output | 1 | One-cycle translation flush request |

## Verification
The hardest case to reach is an alias write that is partly blocked by delegation. The bench has to set up the delegation word, then the machine pending and enable words, and only then write the supervisor alias. The checks read back the machine word, not the alias, because the alias view alone would hide bits that were wrongly changed. The status summary bit and the flush request are similar. Each test writes status values built so that exactly one of the FS, XS or translation fields differs from the previous value, which shows which field caused the change.

// File: rtl/csr_wm_pkg.sv
package csr_wm_pkg;

  localparam logic [11:0] A_SSTATUS    = 12'h100;
  localparam logic [11:0] A_SIE        = 12'h104;
  localparam logic [11:0] A_STVEC      = 12'h105;
  localparam logic [11:0] A_SCOUNTEREN = 12'h106;
  localparam logic [11:0] A_SIP        = 12'h144;
  localparam logic [11:0] A_MSTATUS    = 12'h300;
  localparam logic [11:0] A_MISA       = 12'h301;
  localparam logic [11:0] A_MIDELEG    = 12'h303;
  localparam logic [11:0] A_MIE        = 12'h304;
  localparam logic [11:0] A_MTVEC      = 12'h305;
  localparam logic [11:0] A_MCOUNTEREN = 12'h306;
  localparam logic [11:0] A_MIP        = 12'h344;

  localparam int ST_SIE  = 1;
  localparam int ST_MIE  = 3;
  localparam int ST_SPIE = 5;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;
  localparam int ST_FS   = 13;
  localparam int ST_XS   = 15;
  localparam int ST_MPRV = 17;
  localparam int ST_PUM  = 18;
  localparam int ST_MXR  = 19;

  localparam int IP_SSIP = 1;
  localparam int IP_MSIP = 3;
  localparam int IP_STIP = 5;
  localparam int IP_MTIP = 7;
  localparam int IP_SEIP = 9;
  localparam int IP_COP  = 12;

  localparam int ISA_A = 0;
  localparam int ISA_C = 2;
  localparam int ISA_D = 3;
  localparam int ISA_F = 5;
  localparam int ISA_M = 12;

  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_R = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

endpackage

// File: rtl/csr_status_reg.sv
module csr_status_reg
  import csr_wm_pkg::*;
#(
  parameter int XLEN        = 64,
  parameter bit XS_WRITABLE = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            m_we_i,
  input  logic            s_we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] sview_o,
  output logic            flush_o
);

  localparam logic [XLEN-1:0] B1 = XLEN'(1);
  localparam logic [XLEN-1:0] B3 = XLEN'(3);
  localparam logic [XLEN-1:0] FS_M = B3 << ST_FS;
  localparam logic [XLEN-1:0] XS_M = B3 << ST_XS;
  localparam logic [XLEN-1:0] S_MASK = (B1 << ST_SIE) | (B1 << ST_SPIE) | (B1 << ST_SPP)
                                     | FS_M | XS_M | (B1 << ST_PUM);
  localparam logic [XLEN-1:0] M_MASK = (B1 << ST_SIE) | (B1 << ST_SPIE) | (B1 << ST_MIE)
                                     | (B1 << ST_MPIE) | (B1 << ST_SPP) | FS_M
                                     | (B1 << ST_MPRV) | (B1 << ST_PUM) | (B3 << ST_MPP)
                                     | (B1 << ST_MXR) | (XS_WRITABLE ? XS_M : '0);
  localparam logic [XLEN-1:0] VM_MASK = (B3 << ST_MPP) | (B1 << ST_MPRV)
                                      | (B1 << ST_PUM) | (B1 << ST_MXR);
  localparam logic [XLEN-1:0] SD_BIT = B1 << (XLEN-1);

  logic [XLEN-1:0] st_q, cand, st_d;
  logic            flush_q, dirty;

  always_comb begin
    cand = wdata_i;
    if (s_we_i) cand = (st_q & ~S_MASK) | (wdata_i & S_MASK);
    st_d = st_q;
    if (m_we_i || s_we_i) st_d = (st_q & ~M_MASK) | (cand & M_MASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= '0;
      flush_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      flush_q <= m_we_i && (((wdata_i ^ st_q) & VM_MASK) != '0);
    end
  end

  assign dirty    = ((st_q & FS_M) == FS_M) || ((st_q & XS_M) == XS_M);
  assign status_o = st_q | (dirty ? SD_BIT : '0);
  assign sview_o  = (st_q & S_MASK) | (dirty ? SD_BIT : '0);
  assign flush_o  = flush_q;

  // R10: a flush request only follows a machine status write
  a_r10_flush_after_mwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(m_we_i));

  // R4: writing FS as dirty makes the summary bit read 1
  a_r4_sd_on_fs_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_we_i && ((wdata_i & FS_M) == FS_M)) |=> status_o[XLEN-1]);

  // R3: an alias write leaves the machine-only fields untouched
  a_r3_alias_keeps_m: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_we_i |=> $stable(status_o & ~S_MASK & ~SD_BIT));

endmodule

// File: rtl/csr_irq_regs.sv
module csr_irq_regs
  import csr_wm_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mip_we_i,
  input  logic            sip_we_i,
  input  logic            mie_we_i,
  input  logic            sie_we_i,
  input  logic            deleg_we_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            msip_i,
  input  logic            mtip_i,
  output logic [XLEN-1:0] pend_o,
  output logic [XLEN-1:0] enab_o,
  output logic [XLEN-1:0] deleg_o
);

  localparam logic [XLEN-1:0] B1 = XLEN'(1);
  localparam logic [XLEN-1:0] SW_MASK = (B1 << IP_SSIP) | (B1 << IP_STIP);
  localparam logic [XLEN-1:0] DLG_MASK = (B1 << IP_SSIP) | (B1 << IP_STIP)
                                       | (B1 << IP_SEIP) | (B1 << IP_COP);
  localparam logic [XLEN-1:0] EN_MASK = DLG_MASK | (B1 << IP_MSIP) | (B1 << IP_MTIP);

  logic [XLEN-1:0] sw_q, en_q, dlg_q;
  logic [XLEN-1:0] sw_d, en_d, dlg_d, s_pmask, en_src;

  always_comb begin
    s_pmask = (B1 << IP_SSIP) & dlg_q;
    sw_d = sw_q;
    if (mip_we_i) sw_d = (sw_q & ~SW_MASK) | (wdata_i & SW_MASK);
    else if (sip_we_i) sw_d = (sw_q & ~s_pmask) | (wdata_i & s_pmask);

    en_src = sie_we_i ? ((en_q & ~dlg_q) | (wdata_i & dlg_q)) : wdata_i;
    en_d = en_q;
    if (mie_we_i || sie_we_i) en_d = (en_q & ~EN_MASK) | (en_src & EN_MASK);

    dlg_d = dlg_q;
    if (deleg_we_i) dlg_d = wdata_i & DLG_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= '0;
      en_q  <= '0;
      dlg_q <= '0;
    end else begin
      sw_q  <= sw_d;
      en_q  <= en_d;
      dlg_q <= dlg_d;
    end
  end

  assign pend_o  = sw_q | (msip_i ? (B1 << IP_MSIP) : '0) | (mtip_i ? (B1 << IP_MTIP) : '0);
  assign enab_o  = en_q;
  assign deleg_o = dlg_q;

  // R1: software pending bits only move on a pending write
  a_r1_pend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mip_we_i || sip_we_i) |=> $stable(sw_q));

  // R5: alias pending write is blocked without delegation
  a_r5_sip_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sip_we_i && !mip_we_i && !dlg_q[IP_SSIP]) |=> $stable(sw_q));

  // R5: alias enable write leaves undelegated positions alone
  a_r5_sie_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sie_we_i && !mie_we_i) |=> ((en_q & ~dlg_q) == ($past(en_q) & ~dlg_q)));

endmodule

// File: rtl/csr_tvec_reg.sv
module csr_tvec_reg #(
  parameter int              XLEN      = 64,
  parameter logic [XLEN-1:0] RESET_VAL = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] base_o
);

  logic [XLEN-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= RESET_VAL & ~XLEN'(3);
    else if (we_i) base_q <= {wdata_i[XLEN-1:2], 2'b00};
  end

  assign base_o = base_q;

  // R6: the stored base equals the written data with the low pair cleared
  a_r6_tvec_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (base_o == ($past(wdata_i) & ~XLEN'(3))));

endmodule

// File: rtl/csr_misa_reg.sv
module csr_misa_reg
  import csr_wm_pkg::*;
#(
  parameter int              XLEN    = 64,
  parameter logic [XLEN-1:0] MAX_ISA = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] isa_o
);

  localparam logic [XLEN-1:0] B1 = XLEN'(1);
  localparam logic [XLEN-1:0] W_MASK = ((B1 << ISA_M) | (B1 << ISA_A) | (B1 << ISA_F)
                                      | (B1 << ISA_D) | (B1 << ISA_C)) & MAX_ISA;

  logic [XLEN-1:0] isa_q, wfix;

  always_comb begin
    wfix = wdata_i;
    if (!wdata_i[ISA_F]) wfix[ISA_D] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isa_q <= MAX_ISA;
    else if (we_i) isa_q <= (isa_q & ~W_MASK) | (wfix & W_MASK);
  end

  assign isa_o = isa_q;

  // R7: clearing F in a write never leaves D set
  a_r7_d_needs_f: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wdata_i[ISA_F]) |=> !isa_o[ISA_D]);

  // R7: non-writable bits never move
  a_r7_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 ((isa_o & ~W_MASK) == (MAX_ISA & ~W_MASK)));

endmodule

// File: rtl/csr_ctr_gate.sv
module csr_ctr_gate
  import csr_wm_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0]  priv_i,
  input  logic [11:0] addr_i,
  input  logic [31:0] m_en_i,
  input  logic [31:0] s_en_i,
  output logic        is_ctr_o,
  output logic        ok_o
);

  localparam logic [6:0] LO_PAGE = 7'h60;
  localparam logic [6:0] HI_PAGE = 7'h64;

  logic [31:0] en;

  always_comb begin
    en = '1;
    if (priv_i != PRIV_M) en = en & m_en_i;
    if (priv_i == PRIV_U) en = en & s_en_i;
  end

  assign is_ctr_o = (addr_i[11:5] == LO_PAGE) || ((XLEN == 32) && (addr_i[11:5] == HI_PAGE));
  assign ok_o     = en[addr_i[4:0]];

endmodule

// File: rtl/csr_wmask_unit.sv
module csr_wmask_unit
  import csr_wm_pkg::*;
#(
  parameter int              XLEN        = 64,
  parameter bit              XS_WRITABLE = 1'b1,
  parameter logic [XLEN-1:0] MTVEC_RESET = XLEN'(32'h100),
  parameter logic [XLEN-1:0] MAX_ISA     = {(XLEN == 64) ? 2'b10 : 2'b01, {(XLEN-2){1'b0}}}
                                         | XLEN'(32'h0014_112D)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      priv_i,
  input  logic [11:0]     csr_addr_i,
  input  logic            csr_wr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  input  logic            hw_msip_i,
  input  logic            hw_mtip_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            csr_illegal_o,
  output logic            tlb_flush_o
);

  localparam int NVEC = 2;
  localparam logic [11:0] VEC_ADDR [NVEC] = '{A_MTVEC, A_STVEC};

  function automatic logic [XLEN-1:0] vec_reset(input int idx);
    return (idx == 0) ? MTVEC_RESET : '0;
  endfunction

  logic [XLEN-1:0] status, sview, pend, enab, deleg, isa;
  logic [XLEN-1:0] vec_base [NVEC];
  logic [31:0]     m_en_q, s_en_q;
  logic            is_ctr, ctr_ok, hpm_zero;

  function automatic logic hit(input logic [11:0] a);
    return csr_wr_i && (csr_addr_i == a);
  endfunction

  csr_status_reg #(.XLEN(XLEN), .XS_WRITABLE(XS_WRITABLE)) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .m_we_i(hit(A_MSTATUS)), .s_we_i(hit(A_SSTATUS)),
    .wdata_i(csr_wdata_i),
    .status_o(status), .sview_o(sview), .flush_o(tlb_flush_o)
  );

  csr_irq_regs #(.XLEN(XLEN)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .mip_we_i(hit(A_MIP)), .sip_we_i(hit(A_SIP)),
    .mie_we_i(hit(A_MIE)), .sie_we_i(hit(A_SIE)),
    .deleg_we_i(hit(A_MIDELEG)),
    .wdata_i(csr_wdata_i), .msip_i(hw_msip_i), .mtip_i(hw_mtip_i),
    .pend_o(pend), .enab_o(enab), .deleg_o(deleg)
  );

  csr_misa_reg #(.XLEN(XLEN), .MAX_ISA(MAX_ISA)) u_misa (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(hit(A_MISA)), .wdata_i(csr_wdata_i), .isa_o(isa)
  );

  for (genvar g = 0; g < NVEC; g++) begin : g_vec
    csr_tvec_reg #(.XLEN(XLEN), .RESET_VAL(vec_reset(g))) u_vec (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .we_i(hit(VEC_ADDR[g])), .wdata_i(csr_wdata_i), .base_o(vec_base[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en_q <= '0;
      s_en_q <= '0;
    end else begin
      if (hit(A_MCOUNTEREN)) m_en_q <= csr_wdata_i[31:0];
      if (hit(A_SCOUNTEREN)) s_en_q <= csr_wdata_i[31:0];
    end
  end

  csr_ctr_gate #(.XLEN(XLEN)) u_gate (
    .priv_i(priv_i), .addr_i(csr_addr_i),
    .m_en_i(m_en_q), .s_en_i(s_en_q),
    .is_ctr_o(is_ctr), .ok_o(ctr_ok)
  );

  assign hpm_zero = ((csr_addr_i >= 12'hB03) && (csr_addr_i <= 12'hB1F))
                 || ((XLEN == 32) && (csr_addr_i >= 12'hB83) && (csr_addr_i <= 12'hB9F))
                 || ((csr_addr_i >= 12'h323) && (csr_addr_i <= 12'h33F));

  always_comb begin
    csr_rdata_o   = '0;
    csr_illegal_o = 1'b0;
    if (is_ctr) begin
      csr_illegal_o = !ctr_ok;
    end else if (!hpm_zero) begin
      unique case (csr_addr_i)
        A_MSTATUS:    csr_rdata_o = status;
        A_SSTATUS:    csr_rdata_o = sview;
        A_MISA:       csr_rdata_o = isa;
        A_MIDELEG:    csr_rdata_o = deleg;
        A_MIE:        csr_rdata_o = enab;
        A_SIE:        csr_rdata_o = enab & deleg;
        A_MIP:        csr_rdata_o = pend;
        A_SIP:        csr_rdata_o = pend & deleg;
        A_MTVEC:      csr_rdata_o = vec_base[0];
        A_STVEC:      csr_rdata_o = vec_base[1];
        A_MCOUNTEREN: csr_rdata_o = XLEN'(m_en_q);
        A_SCOUNTEREN: csr_rdata_o = XLEN'(s_en_q);
        default:      csr_illegal_o = 1'b1;
      endcase
    end
  end

  // R11: an illegal access never returns data
  a_r11_illegal_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |-> (csr_rdata_o == '0));

  // R8: machine mode always reaches the user counter page
  a_r8_mmode_ctr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((priv_i == PRIV_M) && (csr_addr_i[11:5] == 7'h60)) |-> !csr_illegal_o);

  // R9: performance counter slots are legal and read zero
  a_r9_hpm_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((csr_addr_i >= 12'hB03) && (csr_addr_i <= 12'hB1F)) |-> (!csr_illegal_o && csr_rdata_o == '0));

endmodule

// File: tb/csr_wmask_unit_tb.sv
module csr_wmask_unit_tb;

  localparam int XLEN = 64;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      priv = 2'd3;
  logic [11:0]     addr = '0;
  logic            wr = 1'b0;
  logic [XLEN-1:0] wdata = '0;
  logic            msip = 1'b0;
  logic            mtip = 1'b0;
  logic [XLEN-1:0] rdata;
  logic            illegal;
  logic            flush;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_wmask_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .priv_i(priv),
    .csr_addr_i(addr), .csr_wr_i(wr), .csr_wdata_i(wdata),
    .hw_msip_i(msip), .hw_mtip_i(mtip),
    .csr_rdata_o(rdata), .csr_illegal_o(illegal), .tlb_flush_o(flush)
  );

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_csr(input logic [11:0] a, input logic [XLEN-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_csr(input logic [11:0] a, output logic [XLEN-1:0] d, output logic ill);
    addr = a;
    #1;
    d = rdata;
    ill = illegal;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [XLEN-1:0] exp,
                        input logic exp_ill);
    logic [XLEN-1:0] d;
    logic ill;
    rd_csr(a, d, ill);
    chk(req, d, exp);
    chk(req, XLEN'(ill), XLEN'(exp_ill));
  endtask

  task automatic t_reset;
    rd_chk("R6 reset", 12'h300, 64'h0, 1'b0);
    rd_chk("R7 reset", 12'h301, 64'h8000_0000_0014_112D, 1'b0);
    rd_chk("R6 reset", 12'h305, 64'h100, 1'b0);
    chk("R10 reset", XLEN'(flush), 64'h0);
  endtask

  task automatic t_mip;
    wr_csr(12'h344, '1);
    rd_chk("R1 sw bits", 12'h344, 64'h22, 1'b0);
    msip = 1'b1; mtip = 1'b1;
    rd_chk("R1 hw bits", 12'h344, 64'hAA, 1'b0);
    msip = 1'b0; mtip = 1'b0;
    wr_csr(12'h344, 64'h0);
    rd_chk("R1 clear", 12'h344, 64'h0, 1'b0);
  endtask

  task automatic t_mie_deleg;
    wr_csr(12'h304, '1);
    rd_chk("R2 enable", 12'h304, 64'h12AA, 1'b0);
    wr_csr(12'h303, '1);
    rd_chk("R2 deleg", 12'h303, 64'h1222, 1'b0);
  endtask

  task automatic t_status_alias;
    wr_csr(12'h300, 64'h1888);
    chk("R10 mpp change", XLEN'(flush), 64'h1);
    wr_csr(12'h100, '1);
    chk("R10 alias no flush", XLEN'(flush), 64'h0);
    rd_chk("R3 mstatus", 12'h300, 64'h8000_0000_0005_F9AA, 1'b0);
    rd_chk("R3 sstatus", 12'h100, 64'h8000_0000_0005_E122, 1'b0);
    wr_csr(12'h100, 64'h0);
    rd_chk("R3 alias clear", 12'h300, 64'h1888, 1'b0);
  endtask

  task automatic t_sd;
    wr_csr(12'h300, 64'h7888);
    rd_chk("R4 fs dirty", 12'h300, 64'h8000_0000_0000_7888, 1'b0);
    wr_csr(12'h300, 64'h19888);
    rd_chk("R4 xs dirty", 12'h300, 64'h8000_0000_0001_9888, 1'b0);
    wr_csr(12'h300, 64'h3888);
    rd_chk("R4 fs initial", 12'h300, 64'h3888, 1'b0);
  endtask

  task automatic t_sip_sie;
    wr_csr(12'h344, 64'h0);
    wr_csr(12'h303, 64'h2);
    wr_csr(12'h144, '1);
    rd_chk("R5 sip deleg", 12'h344, 64'h2, 1'b0);
    rd_chk("R5 sip view", 12'h144, 64'h2, 1'b0);
    wr_csr(12'h303, 64'h20);
    wr_csr(12'h144, 64'h0);
    rd_chk("R5 sip blocked", 12'h344, 64'h2, 1'b0);
    rd_chk("R5 sip view2", 12'h144, 64'h0, 1'b0);
    wr_csr(12'h304, 64'h0);
    wr_csr(12'h104, '1);
    rd_chk("R5 sie masked", 12'h304, 64'h20, 1'b0);
    rd_chk("R5 sie view", 12'h104, 64'h20, 1'b0);
  endtask

  task automatic t_tvec;
    wr_csr(12'h305, 64'h1237);
    rd_chk("R6 mtvec", 12'h305, 64'h1234, 1'b0);
    wr_csr(12'h105, 64'hFFF);
    rd_chk("R6 stvec", 12'h105, 64'hFFC, 1'b0);
  endtask

  task automatic t_misa;
    wr_csr(12'h301, 64'h0);
    rd_chk("R7 clear", 12'h301, 64'h8000_0000_0014_0100, 1'b0);
    wr_csr(12'h301, 64'h8);
    rd_chk("R7 d without f", 12'h301, 64'h8000_0000_0014_0100, 1'b0);
    wr_csr(12'h301, 64'h28);
    rd_chk("R7 f and d", 12'h301, 64'h8000_0000_0014_0128, 1'b0);
    wr_csr(12'h301, '1);
    rd_chk("R7 all ones", 12'h301, 64'h8000_0000_0014_112D, 1'b0);
  endtask

  task automatic t_ctr;
    wr_csr(12'h306, 64'h0);
    wr_csr(12'h106, 64'h0);
    priv = 2'd3;
    rd_chk("R8 machine", 12'hC05, 64'h0, 1'b0);
    priv = 2'd1;
    rd_chk("R8 sup blocked", 12'hC05, 64'h0, 1'b1);
    wr_csr(12'h306, 64'h20);
    rd_chk("R8 sup allowed", 12'hC05, 64'h0, 1'b0);
    priv = 2'd0;
    rd_chk("R8 user blocked", 12'hC05, 64'h0, 1'b1);
    wr_csr(12'h106, 64'h20);
    rd_chk("R8 user allowed", 12'hC05, 64'h0, 1'b0);
    rd_chk("R8 other index", 12'hC06, 64'h0, 1'b1);
    priv = 2'd3;
  endtask

  task automatic t_hpm;
    rd_chk("R9 counter", 12'hB03, 64'h0, 1'b0);
    rd_chk("R9 counter top", 12'hB1F, 64'h0, 1'b0);
    rd_chk("R9 event", 12'h323, 64'h0, 1'b0);
  endtask

  task automatic t_flush;
    wr_csr(12'h300, 64'h3888);
    chk("R10 same value", XLEN'(flush), 64'h0);
    wr_csr(12'h300, 64'h83888);
    chk("R10 mxr change", XLEN'(flush), 64'h1);
    @(negedge clk);
    chk("R10 one cycle", XLEN'(flush), 64'h0);
    wr_csr(12'h300, 64'h85888);
    chk("R10 fs only", XLEN'(flush), 64'h0);
  endtask

  task automatic t_illegal;
    rd_chk("R11 unimpl", 12'h7FF, 64'h0, 1'b1);
    wr_csr(12'h302, '1);
    rd_chk("R11 write ignored", 12'h300, 64'h8_5888, 1'b0);
    rd_chk("R11 write ignored deleg", 12'h303, 64'h20, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mip();
    t_mie_deleg();
    t_status_alias();
    t_sd();
    t_sip_sie();
    t_tvec();
    t_misa();
    t_ctr();
    t_hpm();
    t_flush();
    t_illegal();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule